// File: doc/BRIEF.md
# Packed Saturating and Halving Arithmetic Unit

This unit performs SIMD arithmetic on a 32-bit word. A word is read as four 8-bit lanes, as two 16-bit lanes, or as one 32-bit value. The unit adds and subtracts lanes with signed or unsigned clamping. It also has halving forms, which keep the full-precision sum or difference before dividing by two. A cross pairing mode pairs each 16-bit lane of A with the other 16-bit lane of B. In this mode one half of the word adds and the other half subtracts.

The 32-bit mode has signed clamping add and subtract, plus doubling forms. A doubling form first clamps B+B and then adds that value to A, or subtracts it from A, with a second clamp. A saturation flag reports whether a 32-bit operation clamped, so that a sticky status bit outside the unit can collect it. Lane operations never raise the flag.

An operation is presented with `valid_i`. The result is registered and appears one clock later with `valid_o`.

Top module: `simd_sat_alu`

## Requirements
- R1: `op_i[5]`=1 selects 32-bit mode. In that mode `op_i[1]`=1 selects the doubling form and `op_i[0]`=1 selects subtract, and `op_i[4:2]` have no effect. `op_i[5]`=0 selects lane mode. In lane mode `op_i[4]`=1 selects halving, `op_i[3]`=1 selects unsigned, and `op_i[0]`=1 selects subtract. Also in lane mode, `op_i[2:1]` picks the shape: 00 four 8-bit lanes, 01 two 16-bit lanes, 10 cross add-subtract, 11 cross subtract-add.
- R2: A signed clamping lane operation sign-extends both lanes and computes the exact result. It returns the result clamped to the lane's signed range.
- R3: An unsigned clamping lane operation zero-extends both lanes. It returns the exact result clamped to the range 0 to 2^W-1, where W is the lane width.
- R4: A halving lane operation forms the exact result one bit wider than the lane, then returns its upper W bits. A signed result therefore shifts arithmetically. An unsigned difference that is negative returns a value with the top bit set.
- R5: In the cross add-subtract shape, the low lane is A.lo−B.hi and the high lane is A.hi+B.lo. The cross subtract-add shape computes A.lo+B.hi low and A.hi−B.lo high. `op_i[0]` has no effect in either cross shape, and each lane obeys R2 to R4.
- R6: In 32-bit mode without doubling, the result is A±B clamped to the signed 32-bit range. `sat_o` is 1 exactly when clamping occurred.
- R7: In a doubling form, D = clamp(B+B) and the result is clamp(A±D). `sat_o` is 1 if either step clamped.
- R8: Every lane-mode operation gives `sat_o`=0.
- R9: `res_o` and `sat_o` update one clock after `valid_i`=1, and `valid_o` is `valid_i` delayed one clock. A cycle with `valid_i`=0 leaves `res_o` and `sat_o` unchanged.
- R10: While `rst_ni` is low, `res_o`, `sat_o` and `valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 6 | Operation code (R1) |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| valid_o | output | 1 | Result valid |
| res_o | output | 32 | Registered result |
| sat_o | output | 1 | 32-bit operation clamped |

## Verification
A lane slice whose clamp select or extension bit is wrong shows up as a single corrupted byte or halfword. It appears in the cycle after the operation, and the per-clock comparison against the behavioural model catches it there. A crossed partner index or an inverted per-lane direction in the cross shapes corrupts one half of `res_o` with the same one-cycle latency. A doubling chain that drops the first-step flag only shows up when B+B overflows and A±D does not, so directed vectors aim at that case. A hold-register fault shows up as `res_o` changing during idle cycles.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int OP_W       = 6;
  localparam int OP_MODE32  = 5;
  localparam int OP_HALVE   = 4;
  localparam int OP_UNS     = 3;
  localparam int OP_DBL     = 1;
  localparam int OP_SUB     = 0;

  typedef enum logic [1:0] {
    SHP_L8  = 2'b00,
    SHP_L16 = 2'b01,
    SHP_ASX = 2'b10,
    SHP_SAX = 2'b11
  } shape_e;

  typedef struct packed {
    logic   mode32;
    logic   halve;
    logic   uns;
    shape_e shape;
    logic   dbl;
    logic   sub;
  } op_dec_t;

  function automatic op_dec_t decode_op(logic [OP_W-1:0] op);
    op_dec_t d;
    d.mode32 = op[OP_MODE32];
    d.halve  = op[OP_HALVE];
    d.uns    = op[OP_UNS];
    d.shape  = shape_e'(op[2:1]);
    d.dbl    = op[OP_DBL];
    d.sub    = op[OP_SUB];
    return d;
  endfunction
endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         uns_i,
  input  logic         halve_i,
  output logic [W-1:0] res_o,
  output logic         clamp_o
);
  logic [W:0] ea, eb, ex;
  logic       ovf;

  assign ea = {uns_i ? 1'b0 : a_i[W-1], a_i};
  assign eb = {uns_i ? 1'b0 : b_i[W-1], b_i};
  assign ex = sub_i ? (ea - eb) : (ea + eb);
  // signed: top two bits disagree; unsigned: carry or borrow out
  assign ovf = uns_i ? ex[W] : (ex[W] ^ ex[W-1]);

  always_comb begin
    clamp_o = 1'b0;
    if (halve_i) begin
      res_o = ex[W:1];
    end else if (!ovf) begin
      res_o = ex[W-1:0];
    end else begin
      clamp_o = 1'b1;
      if (uns_i)      res_o = sub_i ? '0 : '1;
      else if (ex[W]) res_o = {1'b1, {(W-1){1'b0}}};
      else            res_o = {1'b0, {(W-1){1'b1}}};
    end
  end
endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
  import simd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  shape_e            shape_i,
  input  logic              sub_i,
  input  logic              uns_i,
  input  logic              halve_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int N8  = DATA_W / 8;
  localparam int N16 = DATA_W / 16;

  logic [DATA_W-1:0] r8, r16;
  logic [N8-1:0]     c8_unused;
  logic [N16-1:0]    c16_unused;

  for (genvar i = 0; i < N8; i++) begin : g_l8
    simd_lane_unit #(.W(8)) u_lane (
      .a_i(a_i[i*8 +: 8]), .b_i(b_i[i*8 +: 8]),
      .sub_i(sub_i), .uns_i(uns_i), .halve_i(halve_i),
      .res_o(r8[i*8 +: 8]), .clamp_o(c8_unused[i])
    );
  end

  for (genvar j = 0; j < N16; j++) begin : g_l16
    localparam int  PART = j ^ 1;
    localparam bit  ODD  = (j % 2) == 1;
    logic [15:0] b_sel;
    logic        sub_sel;
    // cross shapes: partner lane of B, even lane direction set by shape
    assign b_sel   = (shape_i == SHP_L16) ? b_i[j*16 +: 16] : b_i[PART*16 +: 16];
    assign sub_sel = (shape_i == SHP_L16) ? sub_i
                   : ((shape_i == SHP_ASX) ? !ODD : ODD);
    simd_lane_unit #(.W(16)) u_lane (
      .a_i(a_i[j*16 +: 16]), .b_i(b_sel),
      .sub_i(sub_sel), .uns_i(uns_i), .halve_i(halve_i),
      .res_o(r16[j*16 +: 16]), .clamp_o(c16_unused[j])
    );
  end

  assign res_o = (shape_i == SHP_L8) ? r8 : r16;
endmodule

// File: rtl/simd_sat32_unit.sv
module simd_sat32_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         dbl_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  logic [W-1:0] dbl_val, b_sel;
  logic         dbl_clamp, main_clamp;

  simd_lane_unit #(.W(W)) u_dbl (
    .a_i(b_i), .b_i(b_i), .sub_i(1'b0), .uns_i(1'b0), .halve_i(1'b0),
    .res_o(dbl_val), .clamp_o(dbl_clamp)
  );

  assign b_sel = dbl_i ? dbl_val : b_i;

  simd_lane_unit #(.W(W)) u_main (
    .a_i(a_i), .b_i(b_sel), .sub_i(sub_i), .uns_i(1'b0), .halve_i(1'b0),
    .res_o(res_o), .clamp_o(main_clamp)
  );

  assign sat_o = main_clamp | (dbl_i & dbl_clamp);
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic              sat_o
);
  op_dec_t           dec;
  logic [DATA_W-1:0] lane_res, wide_res, nxt_res;
  logic              wide_sat, nxt_sat;

  assign dec = decode_op(op_i);

  simd_lane_array #(.DATA_W(DATA_W)) u_lanes (
    .a_i(a_i), .b_i(b_i), .shape_i(dec.shape), .sub_i(dec.sub),
    .uns_i(dec.uns), .halve_i(dec.halve), .res_o(lane_res)
  );

  simd_sat32_unit #(.W(DATA_W)) u_wide (
    .a_i(a_i), .b_i(b_i), .dbl_i(dec.dbl), .sub_i(dec.sub),
    .res_o(wide_res), .sat_o(wide_sat)
  );

  assign nxt_res = dec.mode32 ? wide_res : lane_res;
  assign nxt_sat = dec.mode32 & wide_sat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      sat_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o <= nxt_res;
        sat_o <= nxt_sat;
      end
    end
  end
endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [5:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] res_o,
  input logic              sat_o
);
  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_IDLE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(sat_o))); // R9
  AST_LANE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i[5]) |=> !sat_o); // R8
  AST_MIXED_SIGN_NO_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[5] && !op_i[1] && !op_i[0] &&
     (a_i[DATA_W-1] != b_i[DATA_W-1])) |=> !sat_o); // R6
  AST_UADD_NOT_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 6'b001000) |=> (res_o[7:0] >= $past(a_i[7:0]))); // R3
  AST_HALVE_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 6'b010010 && a_i == b_i) |=> (res_o == $past(a_i))); // R4
endmodule

bind simd_sat_alu simd_sat_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .res_o(res_o), .sat_o(sat_o)
);

// File: tb/simd_sat_alu_tb_top.sv
module simd_sat_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [5:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        valid_o, sat_o;
  logic [31:0] res_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_res = '0;
  logic        m_sat = 1'b0, m_valid = 1'b0;
  string       m_tag = "R10", m_sat_tag = "R10", m_vtag = "R10";

  always #5 clk_i = ~clk_i;

  simd_sat_alu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .res_o(res_o), .sat_o(sat_o)
  );

  function automatic longint sx(longint v, int w);
    return (v >= (longint'(1) << (w-1))) ? v - (longint'(1) << w) : v;
  endfunction

  function automatic longint lane_ref(longint a, longint b, int w, bit uns,
                                      bit halve, bit sub, output bit clamp);
    longint ea, eb, e, mask, hi, lo;
    mask  = (longint'(1) << w) - 1;
    ea    = uns ? a : sx(a, w);
    eb    = uns ? b : sx(b, w);
    e     = sub ? ea - eb : ea + eb;
    clamp = 1'b0;
    if (halve) return (e >>> 1) & mask;
    if (uns) begin
      hi = mask; lo = 0;
    end else begin
      hi = (longint'(1) << (w-1)) - 1; lo = -(longint'(1) << (w-1));
    end
    if (e > hi) begin e = hi; clamp = 1'b1; end
    if (e < lo) begin e = lo; clamp = 1'b1; end
    return e & mask;
  endfunction

  task automatic model(bit v, logic [5:0] op, logic [31:0] a, logic [31:0] b);
    bit c1, c2;
    longint d, bb;
    m_vtag = "R9";
    if (!v) begin
      m_valid = 1'b0; m_tag = "R9"; m_sat_tag = "R9";
      return;
    end
    m_valid = 1'b1;
    if (op[5]) begin
      d  = lane_ref(b, b, 32, 1'b0, 1'b0, 1'b0, c1);
      bb = op[1] ? d : longint'(b);
      m_res = 32'(lane_ref(a, bb, 32, 1'b0, 1'b0, op[0], c2));
      m_sat = c2 | (op[1] & c1);
      m_tag = (op[4:2] != 0) ? "R1" : (op[1] ? "R7" : "R6");
      m_sat_tag = m_tag;
    end else begin
      m_sat = 1'b0;
      m_sat_tag = "R8";
      if (op[2:1] >= 2'b10) m_tag = "R5";
      else if (op[4])       m_tag = "R4";
      else if (op[3])       m_tag = "R3";
      else                  m_tag = "R2";
      case (op[2:1])
        2'b00: for (int i = 0; i < 4; i++)
          m_res[i*8 +: 8] = 8'(lane_ref(a[i*8 +: 8], b[i*8 +: 8], 8, op[3], op[4], op[0], c1));
        2'b01: for (int i = 0; i < 2; i++)
          m_res[i*16 +: 16] = 16'(lane_ref(a[i*16 +: 16], b[i*16 +: 16], 16, op[3], op[4], op[0], c1));
        default: begin
          m_res[15:0]  = 16'(lane_ref(a[15:0], b[31:16], 16, op[3], op[4], op[2:1] == 2'b10, c1));
          m_res[31:16] = 16'(lane_ref(a[31:16], b[15:0], 16, op[3], op[4], op[2:1] != 2'b10, c2));
        end
      endcase
    end
  endtask

  task automatic check_outputs();
    checks++;
    if (valid_o !== m_valid) begin
      errors++;
      $display("FAIL %s valid_o act=%0b exp=%0b", m_vtag, valid_o, m_valid);
    end
    checks++;
    if (res_o !== m_res) begin
      errors++;
      $display("FAIL %s res_o act=%08h exp=%08h", m_tag, res_o, m_res);
    end
    checks++;
    if (sat_o !== m_sat) begin
      errors++;
      $display("FAIL %s sat_o act=%0b exp=%0b", m_sat_tag, sat_o, m_sat);
    end
  endtask

  task automatic cyc(bit v, logic [5:0] op, logic [31:0] a, logic [31:0] b);
    @(negedge clk_i);
    check_outputs();
    model(v, op, a, b);
    valid_i = v; op_i = op; a_i = a; b_i = b;
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: outputs zero during reset, even with an operation presented
    valid_i = 1'b1; op_i = 6'b100000; a_i = 32'h7fffffff; b_i = 32'h1;
    repeat (3) @(negedge clk_i);
    check_outputs();
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R2 signed clamp 8/16
    cyc(1, 6'b000000, 32'h7f80017f, 32'h01ff0180);
    cyc(1, 6'b000001, 32'h80807f00, 32'h01017f80);
    cyc(1, 6'b000010, 32'h7fff8000, 32'h0001ffff);
    cyc(1, 6'b000011, 32'h80007fff, 32'h0001ffff);
    // R3 unsigned clamp
    cyc(1, 6'b001000, 32'hff80017f, 32'h01800101);
    cyc(1, 6'b001001, 32'h00100010, 32'h00200005);
    cyc(1, 6'b001011, 32'h0000ffff, 32'h00010001);
    // R4 halving incl. unsigned negative difference
    cyc(1, 6'b011001, 32'h00000000, 32'h00010001);
    cyc(1, 6'b010000, 32'h7f7f8080, 32'h7f7f8080);
    cyc(1, 6'b010011, 32'h80007fff, 32'h7fff8000);
    cyc(1, 6'b011010, 32'hffffffff, 32'hffffffff);
    // R5 cross shapes, op_i[0] no effect
    cyc(1, 6'b000100, 32'h7fff8000, 32'h00017fff);
    cyc(1, 6'b000101, 32'h7fff8000, 32'h00017fff);
    cyc(1, 6'b000110, 32'h7fff8000, 32'h00017fff);
    cyc(1, 6'b001101, 32'h00010005, 32'h00020003);
    cyc(1, 6'b011110, 32'h00010005, 32'h00020003);
    // R6 / R7 32-bit
    cyc(1, 6'b100000, 32'h7fffffff, 32'h00000001);
    cyc(1, 6'b100001, 32'h80000000, 32'h00000001);
    cyc(1, 6'b100000, 32'h00000005, 32'h00000003);
    cyc(1, 6'b100010, 32'h00000000, 32'h40000000);
    cyc(1, 6'b100011, 32'hc0000000, 32'hc0000000);
    cyc(1, 6'b100011, 32'h00000010, 32'h00000004);
    // R1 ignored bits in 32-bit mode
    cyc(1, 6'b111100, 32'h7fffffff, 32'h00000001);
    cyc(1, 6'b101110, 32'h00000000, 32'h40000000);
    // R9 idle holds
    cyc(0, 6'b100000, 32'h12345678, 32'h9abcdef0);
    cyc(0, 6'b000000, 32'h0, 32'h0);
    for (int n = 0; n < 4000; n++) begin
      cyc(($urandom % 5) != 0, 6'($urandom), $urandom, $urandom);
    end
    cyc(0, 6'b0, 32'h0, 32'h0);
    cyc(0, 6'b0, 32'h0, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule